// File: doc/BRIEF.md
# Raw Receive Checksum Accumulator

This block sits beside a receive data path and folds the bytes of every incoming Ethernet frame into a 16-bit ones' complement sum. The sum is taken from frame byte 14 (zero-based) onward, so it skips the destination address, the source address and the type/length field. It then runs through the last byte of the frame. If the trailing frame check sequence is still attached, it is included, and downstream logic must subtract it. The result is the uncomplemented sum. Software or a header-parsing stage can later adjust it to verify a partial TCP or UDP checksum without touching the payload again.

Bytes arrive one per beat on a valid/ready input that also marks the first and last byte of each frame. The block never applies back-pressure. Its ready output is high whenever reset is released, so each cycle with valid high transfers one byte, and cycles with valid low are idle gaps that change nothing. The output side is a plain registered checksum with a one-cycle done strobe, meant to be written into a per-frame status record. A build parameter can remove the summing logic. The checksum then reads zero for every frame, while the strobe still marks every frame end.

Top module: `rx_raw_csum`

## Requirements
- R1: Bytes at frame offsets 0 to 13 have no effect on the checksum; changing them leaves the result unchanged.
- R2: Bytes from offset 14 are paired into 16-bit words: the byte at an even distance from offset 14 forms bits 15:8 and the next byte forms bits 7:0.
- R3: Words are added with end-around carry (a carry out of bit 15 is added back into bit 0), and the reported value is the sum itself, not its complement.
- R4: When an odd number of bytes lies at or beyond offset 14, the final byte forms bits 15:8 of a word whose bits 7:0 are zero.
- R5: Every byte up to and including the end-of-frame byte is summed, so an attached four-byte frame check sequence is part of the result.
- R6: A start-of-frame byte clears the running sum and the byte offset, including when the previous frame never ended, and a byte carrying both markers forms a complete one-byte frame.
- R7: csum_done is high for exactly one cycle, in the cycle after the end-of-frame byte is accepted. csum_out takes the new result in that same cycle and holds it until the next csum_done.
- R8: A frame of 14 bytes or fewer yields a checksum of 0x0000.
- R9: With CSUM_EN = 0, csum_out is always 0x0000, and csum_done still pulses for every frame.
- R10: in_ready is high whenever rst_n is high, and cycles with in_valid low leave the running sum and offset untouched.
- R11: While reset is held and after its release, csum_out reads 0x0000 and csum_done reads 0 until the first frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_ready | output | 1 | Byte accepted when high together with in_valid; high out of reset |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Offered byte is frame offset 0 |
| in_eof | input | 1 | Offered byte is the last of the frame |
| csum_out | output | 16 | Raw ones' complement sum of the last finished frame |
| csum_done | output | 1 | One-cycle strobe: csum_out holds a new frame's result |

## Verification
Each result is due exactly one clock edge after the end-of-frame byte is accepted. The bench drives bytes on the falling edge. It checks the strobe and the checksum at the next falling edge, which comes after exactly that one rising edge, and it checks again one falling edge later to confirm that the strobe has dropped and the value is held. Idle gaps are inserted at random inside frames, so a frame end can follow any number of idle cycles. The expected values still attach to the accepted end byte and not to a fixed cycle count from the start of the frame. A second instance built with the function removed runs on the same stimulus and is checked at the same sample points.

// File: rtl/rx_csum_pkg.sv
package rx_csum_pkg;

  localparam int BYTE_W = 8;
  localparam int SUM_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SUM_W-1:0]  sum_t;

  // ones' complement add: carry out of the top bit wraps to bit 0
  function automatic sum_t oc_add(input sum_t a, input sum_t b);
    logic [SUM_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, wide[SUM_W]};
  endfunction

endpackage

// File: rtl/rx_csum_pos.sv
// Tracks the frame offset up to the window start, then only word parity.
module rx_csum_pos #(
  parameter int START_OFS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  output logic in_win,
  output logic odd_pos
);
  localparam int CNT_W = (START_OFS < 1) ? 1 : $clog2(START_OFS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(START_OFS);

  logic [CNT_W-1:0] cnt_q, cnt_cur;
  logic             par_q, par_cur;

  always_comb begin
    cnt_cur = sof ? '0 : cnt_q;
    par_cur = sof ? 1'b0 : par_q;
    in_win  = (cnt_cur == CNT_TOP);
    odd_pos = in_win & par_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (beat) begin
      if (in_win) begin
        cnt_q <= CNT_TOP;
        par_q <= ~par_cur;
      end else begin
        cnt_q <= cnt_cur + 1'b1;
        par_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_csum_acc.sv
// Pairs window bytes into words and keeps the running ones' complement sum.
module rx_csum_acc
  import rx_csum_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat,
  input  logic  sof,
  input  logic  eof,
  input  logic  in_win,
  input  logic  odd_pos,
  input  byte_t data,
  output logic  fin_valid,
  output sum_t  fin_sum
);
  sum_t  acc_q, acc_base, acc_nxt;
  byte_t hi_q, hi_nxt;

  always_comb begin
    acc_base = sof ? '0 : acc_q;
    acc_nxt  = acc_base;
    hi_nxt   = hi_q;
    if (beat && in_win) begin
      if (odd_pos) begin
        acc_nxt = oc_add(acc_base, {hi_q, data});
      end else begin
        hi_nxt = data;
        if (eof) acc_nxt = oc_add(acc_base, {data, {BYTE_W{1'b0}}});
      end
    end
    fin_valid = beat & eof;
    fin_sum   = acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      hi_q  <= '0;
    end else if (beat) begin
      acc_q <= acc_nxt;
      hi_q  <= hi_nxt;
    end
  end

endmodule

// File: rtl/rx_csum_out.sv
// Result register and done strobe; the enable picks the live or zero variant.
module rx_csum_out
  import rx_csum_pkg::*;
#(
  parameter bit CSUM_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fin_valid,
  input  sum_t fin_sum,
  output sum_t csum,
  output logic done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= fin_valid;
  end

  generate
    if (CSUM_EN) begin : g_live
      sum_t csum_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         csum_q <= '0;
        else if (fin_valid) csum_q <= fin_sum;
      end
      assign csum = csum_q;
    end else begin : g_zero
      logic unused_sum;
      assign unused_sum = ^fin_sum;
      assign csum = '0;
    end
  endgenerate

endmodule

// File: rtl/rx_raw_csum.sv
module rx_raw_csum
  import rx_csum_pkg::*;
#(
  parameter bit CSUM_EN   = 1'b1,
  parameter int START_OFS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic [SUM_W-1:0]  csum_out,
  output logic              csum_done
);
  logic beat, in_win, odd_pos, fin_valid;
  sum_t fin_sum;
  logic ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q | rst_n;
  assign beat     = in_valid & in_ready;

  rx_csum_pos #(.START_OFS(START_OFS)) pos_i (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof),
    .in_win(in_win), .odd_pos(odd_pos)
  );

  rx_csum_acc acc_i (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .eof(in_eof),
    .in_win(in_win), .odd_pos(odd_pos), .data(in_data),
    .fin_valid(fin_valid), .fin_sum(fin_sum)
  );

  rx_csum_out #(.CSUM_EN(CSUM_EN)) out_i (
    .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .fin_sum(fin_sum),
    .csum(csum_out), .done(csum_done)
  );

endmodule

// File: rtl/rx_raw_csum_chk.sv
module rx_raw_csum_chk
  import rx_csum_pkg::*;
#(
  parameter bit CSUM_EN   = 1'b1,
  parameter int START_OFS = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_sof,
  input logic              in_eof,
  input logic [SUM_W-1:0]  csum_out,
  input logic              csum_done
);
  logic [15:0] len_q, len_cur;
  logic        short_end_q;

  assign len_cur = (in_sof ? 16'd0 : len_q) + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q       <= '0;
      short_end_q <= 1'b0;
    end else begin
      if (in_valid && in_ready) len_q <= (len_cur == 16'hFFFF) ? len_q : len_cur;
      short_end_q <= in_valid && in_ready && in_eof && (32'(len_cur) <= START_OFS);
    end
  end

  p_done_follows_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eof) |=> csum_done);

  p_done_needs_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csum_done |-> $past(in_valid && in_ready && in_eof));

  p_hold_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !csum_done |-> $stable(csum_out));

  p_short_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    short_end_q |-> (csum_out == '0));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  generate
    if (!CSUM_EN) begin : g_off
      p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csum_out == '0);
    end
  endgenerate

  logic unused_data;
  assign unused_data = ^in_data;

endmodule

bind rx_raw_csum rx_raw_csum_chk #(.CSUM_EN(CSUM_EN), .START_OFS(START_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
  .csum_out(csum_out), .csum_done(csum_done)
);

// File: tb/rx_raw_csum_tb_top.sv
module rx_raw_csum_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        in_ready, in_ready_off;
  logic [15:0] csum_out, csum_off;
  logic        csum_done, done_off;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [7:0] fr [0:1599];

  always #5 clk = ~clk;

  rx_raw_csum dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .csum_out(csum_out), .csum_done(csum_done)
  );

  rx_raw_csum #(.CSUM_EN(1'b0)) dut_off_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_off),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .csum_out(csum_off), .csum_done(done_off)
  );

  function automatic logic [15:0] ref_csum(input int len);
    int unsigned s = 0;
    for (int i = 14; i < len; i += 2) begin
      s += {fr[i], (i + 1 < len) ? fr[i+1] : 8'h00};
      s = (s & 32'hFFFF) + (s >> 16);
    end
    return s[15:0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_rand(input int len);
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
  endtask

  // Sends fr[0:len-1]; when with_eof, checks the result and the strobe timing.
  task automatic send(input int len, input int gap_pct, input bit with_eof,
                      input string req, output logic [15:0] got);
    logic [15:0] exp;
    exp = ref_csum(len);
    got = 16'h0;
    for (int i = 0; i < len; i++) begin
      while ($urandom_range(99) < gap_pct) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fr[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    if (with_eof) begin
      got = csum_out;
      chk({req, " R7 done strobe"}, {15'h0, csum_done}, 16'h1);
      chk(req, csum_out, exp);
      chk("R9 off done", {15'h0, done_off}, 16'h1);
      chk("R9 off zero", csum_off, 16'h0);
      @(negedge clk);
      chk("R7 strobe one cycle", {15'h0, csum_done}, 16'h0);
      chk("R7 value held", csum_out, exp);
    end
  endtask

  initial begin
    logic [15:0] r, r2;
    void'($urandom(32'd20240611));
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 reset csum", csum_out, 16'h0);
    chk("R11 reset done", {15'h0, csum_done}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle csum", csum_out, 16'h0);
    chk("R10 ready", {15'h0, in_ready}, 16'h1);

    // R2: pairing order
    fill_rand(16); fr[14] = 8'h12; fr[15] = 8'h34;
    send(16, 0, 1'b1, "R2 pair order", r);
    chk("R2 literal", r, 16'h1234);

    // R4: odd trailing byte
    fill_rand(15); fr[14] = 8'hAB;
    send(15, 0, 1'b1, "R4 odd pad", r);
    chk("R4 literal", r, 16'hAB00);

    // R3: end-around carry, uncomplemented
    fill_rand(18); fr[14] = 8'h80; fr[15] = 8'h80; fr[16] = 8'h80; fr[17] = 8'h80;
    send(18, 0, 1'b1, "R3 carry wrap", r);
    chk("R3 literal", r, 16'h0101);
    fill_rand(18); for (int i = 14; i < 18; i++) fr[i] = 8'hFF;
    send(18, 0, 1'b1, "R3 all ones", r);
    chk("R3 ones literal", r, 16'hFFFF);

    // R8: short frames
    fill_rand(14);
    send(14, 0, 1'b1, "R8 len14", r);
    chk("R8 len14 zero", r, 16'h0);
    send(1, 0, 1'b1, "R6 R8 sof+eof single byte", r);
    chk("R8 len1 zero", r, 16'h0);

    // R1: header bytes do not matter
    fill_rand(40);
    send(40, 0, 1'b1, "R1 base", r);
    for (int i = 0; i < 14; i++) fr[i] = ~fr[i];
    send(40, 30, 1'b1, "R1 header flipped", r2);
    chk("R1 header no effect", r2, r);

    // R5: trailing check bytes included
    fill_rand(68); fr[64] = 8'hDE; fr[65] = 8'hAD; fr[66] = 8'hBE; fr[67] = 8'hEF;
    send(68, 10, 1'b1, "R5 trailer summed", r);

    // R6: restart without end
    fill_rand(30);
    send(30, 0, 1'b0, "R6 abandoned", r);
    fill_rand(25);
    send(25, 0, 1'b1, "R6 restart", r);

    // R10: long idle gaps
    fill_rand(50);
    send(50, 70, 1'b1, "R10 idle gaps", r);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int len;
      len = $urandom_range(1, 200);
      fill_rand(len);
      send(len, 20, 1'b1, "R2 R3 R4 random frame", r);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule